// File: doc/BRIEF.md
# AT Keyboard Controller Host Register Interface

This block is the processor-facing side of a PC/AT style keyboard controller. The host reaches it through chip select, read and write strobes and one address line. Address line low selects the data port and address line high selects the command and status port. The block holds a one-byte output buffer that the keyboard side fills and a one-byte input buffer that the host writes. An interrupt stays high while the output buffer holds an unread byte. A separate pin reports when the input buffer is empty.

A small set of host commands is decoded directly in logic rather than by a firmware loop. One command produces a timed system-reset pulse. Three commands drive the gate-A20 line: a direct clear, a direct set, and a two-step write whose following data byte supplies the new level. Data bytes that are not claimed by a command go to the serial keyboard side through a valid/ready pop handshake. Received bytes arrive through a valid/ready push handshake.

Both strobes are sampled by the block clock. A write takes effect on the first clock cycle its strobe is seen active. A read drives `host_rdata` combinationally for as long as the read strobe is active, and its side effects take place once the strobe is released.

Top module: `kbc_host_if`

## Requirements
- R1: After reset, the status byte reads 0 apart from bit 2, `host_irq` is 0, `host_ibe` is 1, `gate_a20` is 0, `sys_reset` is 0 and `kb_rx_ready` is 1.
- R2: While `host_cs_n`, `host_rd_n` and `host_a2` are all low, `host_rdata` shows the output-buffer byte and `host_rd_en` is 1; with no read active, `host_rd_en` is 0.
- R3: While a read is active with `host_a2` high, `host_rdata` shows the status byte: bit 0 output-buffer-full, bit 1 input-buffer-full, bit 2 the `sys_flag` input, bit 3 set when the last host write was a command (`host_a2` high) and cleared when it was data, bits 7:4 zero.
- R4: `host_irq` is 1 exactly while the output buffer is full, and it clears in the cycle after the host releases a data-port read strobe.
- R5: A push with `kb_rx_valid` and `kb_rx_ready` both high stores `kb_rx_data` and sets output-buffer-full.
- R6: While the output buffer is full, `kb_rx_ready` is 0 and the buffer contents do not change.
- R7: A data-port write with no two-step command pending sets input-buffer-full, drives `host_ibe` low and presents the byte on `kb_tx_data` with `kb_tx_valid` high until a pop with `kb_tx_ready` high empties the buffer.
- R8: A command-port write is consumed one cycle after the write is captured, so input-buffer-full clears without any pop from the keyboard side.
- R9: Command 0xFE raises `sys_reset` RESET_DELAY+1 cycles after the write is captured and holds it for exactly RESET_WIDTH cycles.
- R10: Command 0xDD clears `gate_a20` and command 0xDF sets it.
- R11: Command 0xD1 followed by a data-port write sets `gate_a20` to bit 1 of that data byte, and that byte never reaches `kb_tx_valid`.
- R12: Any other command byte is consumed without changing `gate_a20`, `sys_reset` or the keyboard-side outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| host_cs_n | input | 1 | Chip select, active low |
| host_rd_n | input | 1 | Read strobe, active low |
| host_wr_n | input | 1 | Write strobe, active low |
| host_a2 | input | 1 | Port select: 0 data, 1 command/status |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data |
| host_rd_en | output | 1 | High while a read is active (data bus drive enable) |
| host_irq | output | 1 | Output-buffer-full interrupt |
| host_ibe | output | 1 | Input buffer empty |
| sys_flag | input | 1 | System flag shown in status bit 2 |
| kb_rx_valid | input | 1 | Keyboard side offers a received byte |
| kb_rx_data | input | 8 | Received byte |
| kb_rx_ready | output | 1 | Output buffer can take a byte |
| kb_tx_valid | output | 1 | A host data byte waits for the keyboard side |
| kb_tx_data | output | 8 | Byte bound for the keyboard |
| kb_tx_ready | input | 1 | Keyboard side takes the byte |
| gate_a20 | output | 1 | Gate-A20 control line |
| sys_reset | output | 1 | System reset pulse, active high |

## Verification
The bench builds the block with RESET_DELAY = 4 and RESET_WIDTH = 6 instead of the microsecond-scale defaults. With these values the whole reset pulse, from command capture through the falling edge, fits in a dozen cycles. The bench can then count the exact cycle of the rising edge and the exact pulse length, and it can still check that the block ignores an unknown command during a window longer than a full pulse. Buffer behaviour does not depend on the parameters, so the full and empty handshakes, the two-step gate-A20 write and the read-side clearing are reached the same way at any setting.

// File: rtl/kbc_host_pkg.sv
package kbc_host_pkg;

    localparam logic [7:0] CMD_PULSE_RESET = 8'hFE;
    localparam logic [7:0] CMD_A20_WRITE   = 8'hD1;
    localparam logic [7:0] CMD_A20_OFF     = 8'hDD;
    localparam logic [7:0] CMD_A20_ON      = 8'hDF;

    // one captured host write
    typedef struct packed {
        logic       valid;
        logic       is_cmd;
        logic [7:0] data;
    } host_wr_t;

    // end of a host read
    typedef struct packed {
        logic done;
        logic sel_status;
    } host_rd_t;

    typedef enum logic [1:0] {
        PT_IDLE  = 2'd0,
        PT_WAIT  = 2'd1,
        PT_PULSE = 2'd2
    } pulse_state_e;

    function automatic logic [7:0] pack_status(input logic obf, input logic ibf,
                                               input logic sysf, input logic last_cmd);
        return {4'b0000, last_cmd, sysf, ibf, obf};
    endfunction

    function automatic logic a20_from_byte(input logic [7:0] b);
        return b[1];
    endfunction

endpackage

// File: rtl/kbc_bus_decode.sv
module kbc_bus_decode
    import kbc_host_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_n,
    input  logic       rd_n,
    input  logic       wr_n,
    input  logic       a2,
    input  logic [7:0] wdata,
    output host_wr_t   wr_ev,
    output host_rd_t   rd_ev,
    output logic       rd_act
);
    logic wr_act;
    logic wr_q;
    logic rd_q;
    logic rd_a2_q;

    assign wr_act = !cs_n && !wr_n;
    assign rd_act = !cs_n && !rd_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q    <= 1'b0;
            rd_q    <= 1'b0;
            rd_a2_q <= 1'b0;
        end else begin
            wr_q <= wr_act;
            rd_q <= rd_act;
            if (rd_act) rd_a2_q <= a2;
        end
    end

    always_comb begin
        wr_ev.valid  = wr_act && !wr_q;
        wr_ev.is_cmd = a2;
        wr_ev.data   = wdata;
        rd_ev.done       = rd_q && !rd_act;
        rd_ev.sel_status = rd_a2_q;
    end

    // R7: one write event for each strobe
    a_r7_single_write: assert property (@(posedge clk) disable iff (rst)
        wr_ev.valid |=> !wr_ev.valid);

endmodule

// File: rtl/kbc_out_buf.sv
module kbc_out_buf
    import kbc_host_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push_valid,
    input  logic [DW-1:0] push_data,
    output logic          push_ready,
    input  host_rd_t      rd_ev,
    output logic          full,
    output logic [DW-1:0] data
);
    logic fire;
    logic drain;

    assign push_ready = !full;
    assign fire       = push_valid && push_ready;
    assign drain      = rd_ev.done && !rd_ev.sel_status;

    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            data <= '0;
        end else if (fire) begin
            full <= 1'b1;
            data <= push_data;
        end else if (drain) begin
            full <= 1'b0;
        end
    end

    a_r4_read_clears: assert property (@(posedge clk) disable iff (rst)
        (drain && full) |=> !full);

    a_r5_push_stores: assert property (@(posedge clk) disable iff (rst)
        fire |=> (full && data == $past(push_data)));

    a_r6_full_holds: assert property (@(posedge clk) disable iff (rst)
        (full && !drain) |=> (full && $stable(data)));

endmodule

// File: rtl/kbc_pulse_timer.sv
module kbc_pulse_timer
    import kbc_host_pkg::*;
#(
    parameter int DELAY = 20,
    parameter int WIDTH = 48
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic pulse
);
    localparam int MAXC = (DELAY > WIDTH) ? DELAY : WIDTH;
    localparam int CW   = $clog2(MAXC + 1);

    pulse_state_e     state;
    logic [CW-1:0]    cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PT_IDLE;
            cnt   <= '0;
        end else begin
            unique case (state)
                PT_IDLE: begin
                    cnt <= '0;
                    if (start) state <= PT_WAIT;
                end
                PT_WAIT: begin
                    if (cnt == CW'(DELAY - 1)) begin
                        state <= PT_PULSE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PT_PULSE: begin
                    if (cnt == CW'(WIDTH - 1)) begin
                        state <= PT_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= PT_IDLE;
            endcase
        end
    end

    assign pulse = (state == PT_PULSE);

    // checker counter: length of the high phase
    int hi_len;
    always_ff @(posedge clk) begin
        if (rst)        hi_len <= 0;
        else if (pulse) hi_len <= hi_len + 1;
        else            hi_len <= 0;
    end

    a_r9_pulse_width: assert property (@(posedge clk) disable iff (rst)
        $fell(pulse) |-> (hi_len == WIDTH));

    a_r9_not_on_start: assert property (@(posedge clk) disable iff (rst)
        (start && !pulse) |=> !pulse);

endmodule

// File: rtl/kbc_cmd_engine.sv
module kbc_cmd_engine
    import kbc_host_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  host_wr_t   wr_ev,
    output logic       full,
    output logic       last_cmd,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    input  logic       tx_ready,
    output logic       a20,
    output logic       pulse_start
);
    logic [7:0] ibuf;
    logic       a20_pend;
    logic       take_cmd;
    logic       take_a20;
    logic       tx_fire;

    assign take_cmd    = full && last_cmd;
    assign take_a20    = full && !last_cmd && a20_pend;
    assign tx_valid    = full && !last_cmd && !a20_pend;
    assign tx_data     = ibuf;
    assign tx_fire     = tx_valid && tx_ready;
    assign pulse_start = take_cmd && (ibuf == CMD_PULSE_RESET);

    always_ff @(posedge clk) begin
        if (rst) begin
            ibuf     <= '0;
            full     <= 1'b0;
            last_cmd <= 1'b0;
            a20_pend <= 1'b0;
            a20      <= 1'b0;
        end else begin
            if (wr_ev.valid) begin
                ibuf     <= wr_ev.data;
                full     <= 1'b1;
                last_cmd <= wr_ev.is_cmd;
            end else if (take_cmd || take_a20 || tx_fire) begin
                full <= 1'b0;
            end
            if (take_cmd) begin
                a20_pend <= (ibuf == CMD_A20_WRITE);
                if (ibuf == CMD_A20_OFF) a20 <= 1'b0;
                if (ibuf == CMD_A20_ON)  a20 <= 1'b1;
            end
            if (take_a20) begin
                a20      <= a20_from_byte(ibuf);
                a20_pend <= 1'b0;
            end
        end
    end

    a_r8_cmd_consumed: assert property (@(posedge clk) disable iff (rst)
        (take_cmd && !wr_ev.valid) |=> !full);

    a_r10_a20_on: assert property (@(posedge clk) disable iff (rst)
        (take_cmd && ibuf == CMD_A20_ON) |=> a20);

    a_r10_a20_off: assert property (@(posedge clk) disable iff (rst)
        (take_cmd && ibuf == CMD_A20_OFF) |=> !a20);

    a_r11_a20_data: assert property (@(posedge clk) disable iff (rst)
        take_a20 |=> (a20 == $past(ibuf[1])));

    a_r11_no_forward: assert property (@(posedge clk) disable iff (rst)
        a20_pend |-> !tx_valid);

endmodule

// File: rtl/kbc_host_if.sv
module kbc_host_if
    import kbc_host_pkg::*;
#(
    parameter int RESET_DELAY = 20,
    parameter int RESET_WIDTH = 48
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       host_cs_n,
    input  logic       host_rd_n,
    input  logic       host_wr_n,
    input  logic       host_a2,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    output logic       host_rd_en,
    output logic       host_irq,
    output logic       host_ibe,
    input  logic       sys_flag,
    input  logic       kb_rx_valid,
    input  logic [7:0] kb_rx_data,
    output logic       kb_rx_ready,
    output logic       kb_tx_valid,
    output logic [7:0] kb_tx_data,
    input  logic       kb_tx_ready,
    output logic       gate_a20,
    output logic       sys_reset
);
    host_wr_t   wr_ev;
    host_rd_t   rd_ev;
    logic       rd_act;
    logic       ob_full;
    logic [7:0] ob_data;
    logic       ib_full;
    logic       last_cmd;
    logic       pulse_start;
    logic [7:0] status;

    kbc_bus_decode u_dec (
        .clk   (clk),
        .rst   (rst),
        .cs_n  (host_cs_n),
        .rd_n  (host_rd_n),
        .wr_n  (host_wr_n),
        .a2    (host_a2),
        .wdata (host_wdata),
        .wr_ev (wr_ev),
        .rd_ev (rd_ev),
        .rd_act(rd_act)
    );

    kbc_out_buf #(.DW(8)) u_obuf (
        .clk       (clk),
        .rst       (rst),
        .push_valid(kb_rx_valid),
        .push_data (kb_rx_data),
        .push_ready(kb_rx_ready),
        .rd_ev     (rd_ev),
        .full      (ob_full),
        .data      (ob_data)
    );

    kbc_cmd_engine u_cmd (
        .clk        (clk),
        .rst        (rst),
        .wr_ev      (wr_ev),
        .full       (ib_full),
        .last_cmd   (last_cmd),
        .tx_valid   (kb_tx_valid),
        .tx_data    (kb_tx_data),
        .tx_ready   (kb_tx_ready),
        .a20        (gate_a20),
        .pulse_start(pulse_start)
    );

    kbc_pulse_timer #(.DELAY(RESET_DELAY), .WIDTH(RESET_WIDTH)) u_rst (
        .clk  (clk),
        .rst  (rst),
        .start(pulse_start),
        .pulse(sys_reset)
    );

    assign status     = pack_status(ob_full, ib_full, sys_flag, last_cmd);
    assign host_rdata = host_a2 ? status : ob_data;
    assign host_rd_en = rd_act;
    assign host_irq   = ob_full;
    assign host_ibe   = !ib_full;

endmodule

// File: tb/kbc_host_if_test.sv
module kbc_host_if_test;
    localparam int DLY = 4;
    localparam int WID = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, a2 = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       rd_en, irq, ibe;
    logic       sysf = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic       rx_ready;
    logic       tx_valid;
    logic [7:0] tx_data;
    logic       tx_ready = 1'b0;
    logic       a20, sreset;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    kbc_host_if #(.RESET_DELAY(DLY), .RESET_WIDTH(WID)) uut (
        .clk(clk), .rst(rst),
        .host_cs_n(cs_n), .host_rd_n(rd_n), .host_wr_n(wr_n), .host_a2(a2),
        .host_wdata(wdata), .host_rdata(rdata), .host_rd_en(rd_en),
        .host_irq(irq), .host_ibe(ibe), .sys_flag(sysf),
        .kb_rx_valid(rx_valid), .kb_rx_data(rx_data), .kb_rx_ready(rx_ready),
        .kb_tx_valid(tx_valid), .kb_tx_data(tx_data), .kb_tx_ready(tx_ready),
        .gate_a20(a20), .sys_reset(sreset)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic sel, input logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0; a2 = sel; wdata = d;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
    endtask

    // drive a read, sample during strobe, release; returns sampled byte
    task automatic host_read(input logic sel, output logic [7:0] d, output logic en);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; a2 = sel;
        #1;
        d = rdata; en = rd_en;
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic kb_push(input logic [7:0] d);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = d;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d; logic en;
        sysf = 1'b1;
        check("R1 irq", int'(irq), 0);
        check("R1 ibe", int'(ibe), 1);
        check("R1 a20", int'(a20), 0);
        check("R1 sys_reset", int'(sreset), 0);
        check("R1 rx_ready", int'(rx_ready), 1);
        check("R2 rd_en idle", int'(rd_en), 0);
        host_read(1'b1, d, en);
        check("R1 status", int'(d), 'h04);
        check("R3 rd_en status", int'(en), 1);
        sysf = 1'b0;
    endtask

    task automatic t_push_read();
        logic [7:0] d; logic en;
        kb_push(8'hA5);
        check("R5 irq after push", int'(irq), 1);
        check("R6 rx_ready full", int'(rx_ready), 0);
        host_read(1'b1, d, en);
        check("R3 status obf", int'(d), 'h01);
        host_read(1'b0, d, en);
        check("R2 data byte", int'(d), 'hA5);
        check("R2 rd_en data", int'(en), 1);
        check("R4 irq cleared", int'(irq), 0);
        check("R4 rx_ready back", int'(rx_ready), 1);
    endtask

    task automatic t_full_stall();
        logic [7:0] d; logic en;
        kb_push(8'h3C);
        kb_push(8'h77);
        check("R6 irq still", int'(irq), 1);
        host_read(1'b0, d, en);
        check("R6 first byte kept", int'(d), 'h3C);
        check("R4 irq low", int'(irq), 0);
        kb_push(8'h77);
        host_read(1'b0, d, en);
        check("R5 second byte", int'(d), 'h77);
    endtask

    task automatic t_data_tx();
        logic [7:0] d; logic en;
        host_write(1'b0, 8'h5A);
        check("R7 ibe low", int'(ibe), 0);
        check("R7 tx_valid", int'(tx_valid), 1);
        check("R7 tx_data", int'(tx_data), 'h5A);
        host_read(1'b1, d, en);
        check("R3 status ibf data", int'(d), 'h02);
        check("R7 still held", int'(tx_valid), 1);
        @(negedge clk); tx_ready = 1'b1;
        @(negedge clk); tx_ready = 1'b0;
        check("R7 ibe after pop", int'(ibe), 1);
        check("R7 tx_valid after pop", int'(tx_valid), 0);
    endtask

    task automatic t_a20_direct();
        logic [7:0] d; logic en;
        host_write(1'b1, 8'hDF);
        check("R8 ibf set on cmd", int'(ibe), 0);
        @(negedge clk);
        check("R8 cmd consumed", int'(ibe), 1);
        check("R10 a20 set", int'(a20), 1);
        check("R8 no tx", int'(tx_valid), 0);
        host_read(1'b1, d, en);
        check("R3 status cmd flag", int'(d), 'h08);
        host_write(1'b1, 8'hDD);
        @(negedge clk);
        check("R10 a20 clear", int'(a20), 0);
    endtask

    task automatic t_a20_two_step();
        logic [7:0] d; logic en;
        host_write(1'b1, 8'hD1);
        @(negedge clk);
        host_write(1'b0, 8'h02);
        check("R11 not forwarded", int'(tx_valid), 0);
        @(negedge clk);
        check("R11 a20 from bit1", int'(a20), 1);
        check("R11 byte consumed", int'(ibe), 1);
        host_read(1'b1, d, en);
        check("R3 status data flag", int'(d), 'h00);
        host_write(1'b1, 8'hD1);
        @(negedge clk);
        host_write(1'b0, 8'hFD);
        check("R11 not forwarded 2", int'(tx_valid), 0);
        @(negedge clk);
        check("R11 a20 bit1 zero", int'(a20), 0);
        host_write(1'b0, 8'h11);
        check("R11 next data forwarded", int'(tx_valid), 1);
        @(negedge clk); tx_ready = 1'b1;
        @(negedge clk); tx_ready = 1'b0;
    endtask

    task automatic t_reset_pulse();
        int n;
        int rise_at;
        int hi;
        host_write(1'b1, 8'hFE);
        n = 1;
        rise_at = -1;
        for (int k = 0; k < 40; k++) begin
            if (sreset) begin rise_at = n; break; end
            @(negedge clk); n++;
        end
        check("R9 rise cycle", rise_at, DLY + 2);
        hi = 0;
        for (int k = 0; k < 40; k++) begin
            if (!sreset) break;
            hi++;
            @(negedge clk);
        end
        check("R9 pulse width", hi, WID);
    endtask

    task automatic t_unknown();
        int seen;
        host_write(1'b1, 8'hDF);
        @(negedge clk);
        host_write(1'b1, 8'h55);
        seen = 0;
        for (int k = 0; k < DLY + WID + 6; k++) begin
            @(negedge clk);
            if (sreset || tx_valid || !a20) seen++;
        end
        check("R12 no effect", seen, 0);
        check("R12 consumed", int'(ibe), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_push_read();
        t_full_stall();
        t_data_tx();
        t_a20_direct();
        t_a20_two_step();
        t_reset_pulse();
        t_unknown();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule